// File: doc/BRIEF.md
# Masked-Access GPIO with Interrupts

This block is an eight-line general-purpose I/O peripheral on a simple APB-style register bus with byte-wide registers. Each line can be an input or an output under a direction register. The data port spans a whole address window, and the word-address bits pick which lines an access touches. A write through the data port changes only the selected output lines. A read returns zero for every line that is not selected.

Input lines pass through a two-flop synchronizer. Each line then feeds its own event detector. A line can be set to watch a level (high or low), one edge (rising or falling), or both edges. Detected events appear in a raw status register. They are gated by an enable register into a masked status register. The masked bits are ORed into one interrupt line. Latched edge events are cleared by writing ones to a clear register.

Top module: `gpio_mask_irq`

## Requirements
- R1: After reset every register is 0: all lines are inputs (`pinOe` = 0, `pinOut` = 0), all interrupt enables are off, and `irqOut` is low.
- R2: A write to byte offsets 0x000–0x3FC updates output-register bit i only if address bit (i+2) is 1 and line i is an output (direction bit 1). Bits of lines configured as inputs are left unchanged.
- R3: A read from byte offsets 0x000–0x3FC returns 0 in every bit whose address bit (i+2) is 0. An output line returns its driven value. An input line returns its synchronized pin value.
- R4: The direction register is at byte offset 0x400, and a 1 makes the line an output. `pinOe` equals the direction register. `pinOut` shows the stored value only for output lines and is 0 for input lines.
- R5: Pin inputs pass through two flops. A level change that is launched between clock edges is visible to the detectors after the second rising edge that follows it.
- R6: Edge detection is selected when the sense bit (0x404) is 0. If the both-edges bit (0x408) is 1, any transition sets the raw bit (0x414) and the event bit (0x40C) is ignored. Otherwise event bit 1 selects the rising edge and event bit 0 the falling edge. A detected edge stays latched.
- R7: When the sense bit is 1, the raw bit follows the synchronized level: active-high if the event bit is 1, active-low if it is 0. A write to the clear register does not change it.
- R8: Masked status (0x418) is raw status ANDed with the enable register (0x410). `irqOut` is the OR of the masked bits.
- R9: Writing to the clear register (0x41C) clears each latched edge bit whose written bit is 1, and bits written 0 are untouched. An edge detected in the same cycle as a clear of that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus select |
| busEnable | input | 1 | Bus access phase |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | AW-2 | Word address (byte address bits AW-1..2) |
| busWdata | input | NPINS | Write data |
| busRdata | output | NPINS | Read data, valid in the access phase |
| pinIn | input | NPINS | Pin input levels (asynchronous) |
| pinOut | output | NPINS | Pin output values |
| pinOe | output | NPINS | Pin output enables |
| irqOut | output | 1 | Combined interrupt |

## Verification
A write to the clear register and a newly detected edge on the same line can land on the same clock edge. The bench provokes this by raising a line configured for rising-edge detection exactly one cycle before it starts the clear write. The detector output and the clear commit then meet at one edge, and raw status must still hold the bit afterwards. A second overlap is a clear write that hits a level-sensed line while that line is active. Its raw bit must stay set.

// File: rtl/gpio_mask_irq_pkg.sv
package gpio_mask_irq_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_SENSE,
    SEL_BOTH,
    SEL_EVENT,
    SEL_EN,
    SEL_RAW,
    SEL_MASKED
  } rdSel_e;

  typedef struct packed {
    logic dataWr;
    logic dirWr;
    logic senseWr;
    logic bothWr;
    logic eventWr;
    logic enWr;
    logic clrWr;
  } wrStrobe_t;

endpackage

// File: rtl/gpio_mask_irq_ctrl.sv
module gpio_mask_irq_ctrl
  import gpio_mask_irq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 12
) (
  input  logic            busSel,
  input  logic            busEnable,
  input  logic            busWrite,
  input  logic [AW-1:2]   busAddr,
  output wrStrobe_t       strobes,
  output rdSel_e          rdSel,
  output logic [NPINS-1:0] accMask
);
  localparam int HI_LSB = NPINS + 2;
  localparam int HI_W   = AW - HI_LSB;

  logic       access;
  logic       dataHit;
  logic       regHit;
  logic [2:0] regIdx;

  assign access  = busSel & busEnable;
  assign dataHit = (busAddr[AW-1:HI_LSB] == '0);
  assign regHit  = (busAddr[AW-1:HI_LSB] == HI_W'(1)) && (busAddr[HI_LSB-1:5] == '0);
  assign regIdx  = busAddr[4:2];
  assign accMask = busAddr[HI_LSB-1:2];

  always_comb begin
    strobes = '0;
    if (access && busWrite) begin
      if (dataHit) strobes.dataWr = 1'b1;
      if (regHit) begin
        case (regIdx)
          3'd0:    strobes.dirWr   = 1'b1;
          3'd1:    strobes.senseWr = 1'b1;
          3'd2:    strobes.bothWr  = 1'b1;
          3'd3:    strobes.eventWr = 1'b1;
          3'd4:    strobes.enWr    = 1'b1;
          3'd7:    strobes.clrWr   = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (dataHit) rdSel = SEL_DATA;
    else if (regHit) begin
      case (regIdx)
        3'd0:    rdSel = SEL_DIR;
        3'd1:    rdSel = SEL_SENSE;
        3'd2:    rdSel = SEL_BOTH;
        3'd3:    rdSel = SEL_EVENT;
        3'd4:    rdSel = SEL_EN;
        3'd5:    rdSel = SEL_RAW;
        3'd6:    rdSel = SEL_MASKED;
        default: rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_mask_irq_dp.sv
module gpio_mask_irq_dp
  import gpio_mask_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strobes,
  input  rdSel_e           rdSel,
  input  logic [NPINS-1:0] accMask,
  input  logic [NPINS-1:0] wrData,
  output logic [NPINS-1:0] rdData,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irqOut
);
  logic [NPINS-1:0] dirReg, senseReg, bothReg, eventReg, enReg, outReg;
  logic [NPINS-1:0] syncA, syncB, prevLvl;
  logic [NPINS-1:0] edgeLatch, edgeHit, rawStat, maskedStat;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg   <= '0;
      senseReg <= '0;
      bothReg  <= '0;
      eventReg <= '0;
      enReg    <= '0;
    end else begin
      if (strobes.dirWr)   dirReg   <= wrData;
      if (strobes.senseWr) senseReg <= wrData;
      if (strobes.bothWr)  bothReg  <= wrData;
      if (strobes.eventWr) eventReg <= wrData;
      if (strobes.enWr)    enReg    <= wrData;
    end
  end

  // output data: only selected output lines take the write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (strobes.dataWr) begin
      for (int i = 0; i < NPINS; i++)
        if (accMask[i] && dirReg[i]) outReg[i] <= wrData[i];
    end
  end

  // two-flop synchronizer plus history flop for edge compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= '0;
      syncB   <= '0;
      prevLvl <= '0;
    end else begin
      syncA   <= pinIn;
      syncB   <= syncA;
      prevLvl <= syncB;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_det
    logic rise, fall;
    assign rise       = syncB[g] & ~prevLvl[g];
    assign fall       = ~syncB[g] & prevLvl[g];
    assign edgeHit[g] = ~senseReg[g] &
                        (bothReg[g] ? (rise | fall) : (eventReg[g] ? rise : fall));
    assign rawStat[g] = senseReg[g] ? (eventReg[g] ? syncB[g] : ~syncB[g])
                                    : edgeLatch[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) edgeLatch[g] <= 1'b0;
      else if (edgeHit[g]) edgeLatch[g] <= 1'b1;
      else if (strobes.clrWr && wrData[g]) edgeLatch[g] <= 1'b0;
    end
  end

  assign maskedStat = rawStat & enReg;
  assign irqOut     = |maskedStat;
  assign pinOe      = dirReg;
  assign pinOut     = outReg & dirReg;

  always_comb begin
    case (rdSel)
      SEL_DATA:   rdData = accMask & ((dirReg & outReg) | (~dirReg & syncB));
      SEL_DIR:    rdData = dirReg;
      SEL_SENSE:  rdData = senseReg;
      SEL_BOTH:   rdData = bothReg;
      SEL_EVENT:  rdData = eventReg;
      SEL_EN:     rdData = enReg;
      SEL_RAW:    rdData = rawStat;
      SEL_MASKED: rdData = maskedStat;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_mask_irq.sv
module gpio_mask_irq
  import gpio_mask_irq_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busEnable,
  input  logic             busWrite,
  input  logic [AW-1:2]    busAddr,
  input  logic [NPINS-1:0] busWdata,
  output logic [NPINS-1:0] busRdata,
  input  logic [NPINS-1:0] pinIn,
  output logic [NPINS-1:0] pinOut,
  output logic [NPINS-1:0] pinOe,
  output logic             irqOut
);
  wrStrobe_t        strobes;
  rdSel_e           rdSel;
  logic [NPINS-1:0] accMask;

  gpio_mask_irq_ctrl #(.NPINS(NPINS), .AW(AW)) u_ctrl (
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .strobes(strobes), .rdSel(rdSel), .accMask(accMask)
  );

  gpio_mask_irq_dp #(.NPINS(NPINS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel),
    .accMask(accMask), .wrData(busWdata), .rdData(busRdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

endmodule

// File: rtl/gpio_mask_irq_chk.sv
module gpio_mask_irq_chk #(
  parameter int NPINS = 8,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busEnable,
  input logic             busWrite,
  input logic [AW-1:2]    busAddr,
  input logic [NPINS-1:0] busRdata,
  input logic [NPINS-1:0] pinIn,
  input logic [NPINS-1:0] pinOut,
  input logic [NPINS-1:0] pinOe,
  input logic             irqOut
);
  logic anyWr, dirWr, dataRd;
  assign anyWr  = busSel && busEnable && busWrite;
  assign dirWr  = anyWr && (busAddr == (AW-2)'(12'h400 >> 2));
  assign dataRd = busSel && busEnable && !busWrite && (busAddr[AW-1:NPINS+2] == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> (pinOe == '0 && !irqOut));

  // R4
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == '0);

  // R4
  dir_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinOe) |-> $past(dirWr));

  // R2
  out_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pinOut) |-> $past(anyWr));

  // R3
  read_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataRd |-> ((busRdata & ~busAddr[NPINS+1:2]) == '0));

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(anyWr) || ($past(pinIn, 2) != $past(pinIn, 3)) ||
                       ($past(pinIn, 3) != $past(pinIn, 4))));
endmodule

bind gpio_mask_irq gpio_mask_irq_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
  .busWrite(busWrite), .busAddr(busAddr), .busRdata(busRdata),
  .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
);

// File: tb/sim_gpio_mask_irq.sv
`timescale 1ns/1ps
module sim_gpio_mask_irq;
  localparam int NPINS = 8;
  localparam int AW    = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busEnable = 1'b0, busWrite = 1'b0;
  logic [AW-1:2] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] pinIn = '0;
  logic [7:0] pinOut, pinOe;
  logic irqOut;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mask_irq #(.NPINS(NPINS), .AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    nTests++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] addr, input logic [7:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = addr[11:2]; busWdata = data;
    @(negedge clk);
    busEnable = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busEnable = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [11:0] addr, output logic [7:0] data);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = addr[11:2];
    @(negedge clk);
    busEnable = 1'b1;
    #1 data = busRdata;
    @(negedge clk);
    busSel = 1'b0; busEnable = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; pinIn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {byte address, write data, expected full read-back}
  localparam logic [27:0] VECS [5] = '{
    {12'h3FC, 8'hA5, 8'hA5},
    {12'h004, 8'h00, 8'hA4},
    {12'h200, 8'h00, 8'h24},
    {12'h0F0, 8'hFF, 8'h3C},
    {12'h000, 8'hFF, 8'h3C}
  };

  initial begin
    logic [7:0] v;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1;
    chk("R1 pinOe", pinOe, 8'h00);
    chk("R1 pinOut", pinOut, 8'h00);
    chk("R1 irq", {7'd0, irqOut}, 8'h00);
    rd(12'h400, v); chk("R1 dir", v, 8'h00);
    rd(12'h410, v); chk("R1 enable", v, 8'h00);
    rd(12'h414, v); chk("R1 raw", v, 8'h00);

    // R2/R3 masked data writes via table
    wr(12'h400, 8'hFF);
    #1 chk("R4 pinOe all out", pinOe, 8'hFF);
    foreach (VECS[k]) begin
      wr(VECS[k][27:16], VECS[k][15:8]);
      rd(12'h3FC, v);
      chk("R2 masked write", v, VECS[k][7:0]);
      #1 chk("R2 pinOut", pinOut, VECS[k][7:0]);
    end
    rd(12'h00C, v); chk("R3 read mask 03", v, 8'h00);
    rd(12'h0F0, v); chk("R3 read mask 3C", v, 8'h3C);

    // R2/R4 writes to input lines ignored, inputs read synced pins
    doReset();
    wr(12'h400, 8'h0F);
    wr(12'h3FC, 8'hFF);
    #1 chk("R4 pinOut gated", pinOut, 8'h0F);
    chk("R4 pinOe", pinOe, 8'h0F);
    @(negedge clk) pinIn = 8'hA0;
    waitCyc(3);
    rd(12'h3FC, v); chk("R3 mixed read", v, 8'hAF);
    wr(12'h400, 8'hFF);
    #1 chk("R2 input bits not written", pinOut, 8'h0F);

    // R5 synchronizer latency via level interrupt
    doReset();
    wr(12'h404, 8'h08); wr(12'h40C, 8'h08); wr(12'h410, 8'h08);
    @(negedge clk) pinIn = 8'h08;
    @(negedge clk); #1 chk("R5 not yet after 1 edge", {7'd0, irqOut}, 8'h00);
    @(negedge clk); #1 chk("R5 visible after 2 edges", {7'd0, irqOut}, 8'h01);

    // R6/R7/R8/R9 interrupt modes
    doReset();
    wr(12'h404, 8'h18);          // lines 3,4 level
    wr(12'h408, 8'h04);          // line 2 both edges
    wr(12'h40C, 8'h09);          // line0 rising, line3 high, others low/falling
    wr(12'h410, 8'h0F);
    waitCyc(3);
    rd(12'h414, v); chk("R7 active-low level", v, 8'h10);
    rd(12'h418, v); chk("R8 masked idle", v, 8'h00);
    #1 chk("R8 irq idle", {7'd0, irqOut}, 8'h00);
    @(negedge clk) pinIn = 8'h1F;
    waitCyc(4);
    rd(12'h414, v); chk("R6 rising/both/level", v, 8'h0D);
    rd(12'h418, v); chk("R8 masked", v, 8'h0D);
    #1 chk("R8 irq high", {7'd0, irqOut}, 8'h01);
    wr(12'h41C, 8'h00);
    rd(12'h414, v); chk("R9 zero write no effect", v, 8'h0D);
    wr(12'h41C, 8'h0D);
    rd(12'h414, v); chk("R9 clear, R7 level kept", v, 8'h08);
    @(negedge clk) pinIn = 8'h00;
    waitCyc(4);
    rd(12'h414, v); chk("R6 falling/both", v, 8'h16);
    rd(12'h418, v); chk("R8 masked after fall", v, 8'h06);
    wr(12'h41C, 8'h06);
    rd(12'h414, v); chk("R9 clear edges", v, 8'h10);
    #1 chk("R8 irq low", {7'd0, irqOut}, 8'h00);

    // R9 edge wins over same-cycle clear
    @(negedge clk) pinIn = 8'h01;
    wr(12'h41C, 8'h01);
    rd(12'h414, v); chk("R9 edge wins", v, 8'h11);
    wr(12'h41C, 8'h01);
    rd(12'h414, v); chk("R9 later clear", v, 8'h10);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule